// File: doc/BRIEF.md
# Oscillator Loss Monitor with Limp Clock Fallback

This block supervises an external oscillator from a free-running backup clock. The oscillator is treated as a data signal and passes through a two-flop synchronizer clocked by the backup clock. Rising edges are counted once the device has left reset. After enough edges have been seen, detection is armed. If the armed monitor then sees a long enough run of backup cycles with no oscillator rising edge, it moves the system clock select to the backup (limp) clock. It also emits a fixed-length reset request, sets a sticky missing-clock status flag, and holds off the watchdog's decrement enable.

All state lives in the backup clock domain. A power-on reset clears everything. The device reset only disarms the monitor before a loss is declared. After a loss it is ignored, because the requested reset returns through that same input. Detection runs only when the clock mode code says bypass or multiplied operation. In the off mode, or with the reserved code, the monitor drops back to waiting for arming.

The state machine has four states: WAIT_ARM (counting edges), WATCH (armed, timing gaps), RST_PULSE (reset request active, on limp clock) and LIMP (on limp clock, reset request done). The transitions are:
- arm: WAIT_ARM to WATCH
- disarm: WATCH to WAIT_ARM, on device reset or a mode without detection
- loss: WATCH to RST_PULSE
- pulse_done: RST_PULSE to LIMP

LIMP is left only by power-on reset.

Top module: `mcd_limp_monitor`

## Requirements
- R1: After power-on reset (por_n low), clk_sel_limp, rst_req, miss_sts and wd_freeze are all 0.
- R2: Detection arms only after 4 synchronized rising edges of osc_clk. These edges must be counted while dev_rst_n is high and clk_mode allows detection. Edges seen before a pause still count. Before arming, an absent oscillator changes no output.
- R3: Once armed, 16 consecutive backup cycles with no synchronized rising edge cause clk_sel_limp to go to 1 on the next clock edge. Synchronization uses two flops plus one history flop.
- R4: rst_req rises in the same cycle as clk_sel_limp. It stays high for exactly 8 consecutive backup cycles and then stays low.
- R5: miss_sts becomes 1 in the cycle rst_req rises. It is unaffected by dev_rst_n. A one-cycle sts_clr clears it on the next edge; a set in the same cycle wins over the clear.
- R6: wd_freeze is 1 in every cycle where clk_sel_limp is 1, and 0 otherwise.
- R7: clk_mode encodes 2'b00 off, 2'b01 bypass, 2'b10 multiplied and 2'b11 reserved. Only 01 and 10 allow detection. Any other code discards counted edges and disarms the monitor, so no loss is declared.
- R8: dev_rst_n low, sampled on the backup clock before a loss, clears the edge count and disarms. After a loss, dev_rst_n has no effect on any output.
- R9: Once clk_sel_limp is 1, it stays 1 until power-on reset, even if the oscillator resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bkp_clk | input | 1 | Free-running backup clock; clocks all logic |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| dev_rst_n | input | 1 | Device reset, active low, sampled on bkp_clk |
| osc_clk | input | 1 | Monitored external oscillator, used as data |
| clk_mode | input | 2 | Clock mode code (00 off, 01 bypass, 10 multiplied, 11 reserved) |
| sts_clr | input | 1 | Clear strobe for the missing-clock status |
| clk_sel_limp | output | 1 | 1 selects the limp clock for the system |
| rst_req | output | 1 | Device reset request, 8-cycle pulse |
| miss_sts | output | 1 | Sticky missing-clock status |
| wd_freeze | output | 1 | 1 holds the watchdog decrement off |

## Verification
Directed sequences cover several cases. A missing oscillator from power-up must not trip the monitor. Three edges followed by a long pause must not trip it either, while a fourth edge makes the same pause fatal; this pins the arming count. A device reset between edges shows that the count was discarded. Off and reserved mode codes must not trip on long pauses, and restarting the oscillator after a loss must not undo the fallback. Constrained-random oscillator half-periods from 1 to 6 cycles are mixed with random stops, mode changes, clears and device resets. This compares every output every cycle against a bench reference model, which separates gaps of exactly 15 and 16 cycles and checks clear/set ordering.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_ARM  = 2'd0,
        ST_WATCH     = 2'd1,
        ST_RST_PULSE = 2'd2,
        ST_LIMP      = 2'd3
    } mcd_state_e;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_BYPASS = 2'b01,
        MODE_MULT   = 2'b10,
        MODE_RSVD   = 2'b11
    } mcd_mode_e;

    function automatic logic mode_detects(input logic [1:0] code);
        return (code == MODE_BYPASS) || (code == MODE_MULT);
    endfunction

endpackage

// File: rtl/mcd_edge_sync.sv
module mcd_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic async_in,
    output logic rise
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            chain_q[0] <= 1'b0;
        end else begin
            chain_q[0] <= async_in;
        end
    end

    generate
        for (genvar g = 1; g < CHAIN; g++) begin : g_stage
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) begin
                    chain_q[g] <= 1'b0;
                end else begin
                    chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];

endmodule

// File: rtl/mcd_cnt.sv
module mcd_cnt #(
    parameter int LIMIT = 16,
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic por_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_last = (cnt_q == W'(LIMIT - 1));

endmodule

// File: rtl/mcd_status.sv
module mcd_status (
    input  logic clk,
    input  logic por_n,
    input  logic set,
    input  logic clr,
    output logic sts
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sts <= 1'b0;
        end else if (set) begin
            sts <= 1'b1;
        end else if (clr) begin
            sts <= 1'b0;
        end
    end

    // R5: a lone clear empties the flag on the next edge
    a_r5_clear_works: assert property (@(posedge clk) disable iff (!por_n)
        (clr && !set) |=> !sts);

    // R5: a set always leaves the flag high
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!por_n)
        set |=> sts);

endmodule

// File: rtl/mcd_fsm.sv
module mcd_fsm #(
    parameter int RST_CYC = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic rise,
    input  logic det_ok,
    input  logic dev_ok,
    input  logic edge_last,
    input  logic gap_last,
    input  logic pls_last,
    output logic edge_clr,
    output logic gap_clr,
    output logic pls_clr,
    output logic loss_set,
    output logic clk_sel,
    output logic rst_req,
    output logic wd_freeze
);
    import mcd_pkg::*;

    localparam int CW = $clog2(RST_CYC + 1) + 1;

    mcd_state_e state_q, state_d;
    logic       run_ok;

    assign run_ok = det_ok && dev_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_ARM: begin
                if (run_ok && rise && edge_last) begin
                    state_d = ST_WATCH;
                end
            end
            ST_WATCH: begin
                if (!run_ok) begin
                    state_d = ST_WAIT_ARM;
                end else if (!rise && gap_last) begin
                    state_d = ST_RST_PULSE;
                end
            end
            ST_RST_PULSE: begin
                if (pls_last) begin
                    state_d = ST_LIMP;
                end
            end
            ST_LIMP: begin
                state_d = ST_LIMP;
            end
            default: state_d = ST_WAIT_ARM;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_WAIT_ARM;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        edge_clr  = 1'b1;
        gap_clr   = 1'b1;
        pls_clr   = 1'b1;
        loss_set  = 1'b0;
        clk_sel   = 1'b0;
        rst_req   = 1'b0;
        wd_freeze = 1'b0;
        unique case (state_q)
            ST_WAIT_ARM: begin
                edge_clr = !run_ok;
            end
            ST_WATCH: begin
                gap_clr  = rise;
                loss_set = (state_d == ST_RST_PULSE);
            end
            ST_RST_PULSE: begin
                pls_clr   = 1'b0;
                clk_sel   = 1'b1;
                rst_req   = 1'b1;
                wd_freeze = 1'b1;
            end
            ST_LIMP: begin
                clk_sel   = 1'b1;
                wd_freeze = 1'b1;
            end
            default: begin
                edge_clr = 1'b1;
            end
        endcase
    end

    logic [CW-1:0] chk_len_q;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            chk_len_q <= '0;
        end else if (rst_req) begin
            chk_len_q <= chk_len_q + 1'b1;
        end else begin
            chk_len_q <= '0;
        end
    end

    // R4: request never longer than RST_CYC cycles
    a_r4_pulse_not_long: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> (chk_len_q < CW'(RST_CYC)));

    // R4: request drops only after exactly RST_CYC cycles
    a_r4_pulse_exact: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_req) |-> ($past(chk_len_q) == CW'(RST_CYC - 1)));

    // R2: an unarmed monitor cannot jump straight to the fallback
    a_r2_no_unarmed_loss: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_WAIT_ARM) |=> (state_q == ST_WAIT_ARM || state_q == ST_WATCH));

    // R3: fallback begins only from the armed state
    a_r3_loss_from_watch: assert property (@(posedge clk) disable iff (!por_n)
        $rose(clk_sel) |-> ($past(state_q) == ST_WATCH));

endmodule

// File: rtl/mcd_limp_monitor.sv
module mcd_limp_monitor #(
    parameter int SYNC_STAGES = 2,
    parameter int ARM_EDGES   = 4,
    parameter int MISS_CYC    = 16,
    parameter int RST_CYC     = 8
) (
    input  logic       bkp_clk,
    input  logic       por_n,
    input  logic       dev_rst_n,
    input  logic       osc_clk,
    input  logic [1:0] clk_mode,
    input  logic       sts_clr,
    output logic       clk_sel_limp,
    output logic       rst_req,
    output logic       miss_sts,
    output logic       wd_freeze
);
    import mcd_pkg::*;

    logic rise, det_ok;
    logic edge_clr, gap_clr, pls_clr;
    logic edge_last, gap_last, pls_last;
    logic loss_set;

    assign det_ok = mode_detects(clk_mode);

    mcd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (bkp_clk),
        .por_n    (por_n),
        .async_in (osc_clk),
        .rise     (rise)
    );

    mcd_cnt #(.LIMIT(ARM_EDGES)) u_edge_cnt (
        .clk     (bkp_clk),
        .por_n   (por_n),
        .clr     (edge_clr),
        .inc     (rise),
        .at_last (edge_last)
    );

    mcd_cnt #(.LIMIT(MISS_CYC)) u_gap_cnt (
        .clk     (bkp_clk),
        .por_n   (por_n),
        .clr     (gap_clr),
        .inc     (1'b1),
        .at_last (gap_last)
    );

    mcd_cnt #(.LIMIT(RST_CYC)) u_pls_cnt (
        .clk     (bkp_clk),
        .por_n   (por_n),
        .clr     (pls_clr),
        .inc     (1'b1),
        .at_last (pls_last)
    );

    mcd_fsm #(.RST_CYC(RST_CYC)) u_fsm (
        .clk       (bkp_clk),
        .por_n     (por_n),
        .rise      (rise),
        .det_ok    (det_ok),
        .dev_ok    (dev_rst_n),
        .edge_last (edge_last),
        .gap_last  (gap_last),
        .pls_last  (pls_last),
        .edge_clr  (edge_clr),
        .gap_clr   (gap_clr),
        .pls_clr   (pls_clr),
        .loss_set  (loss_set),
        .clk_sel   (clk_sel_limp),
        .rst_req   (rst_req),
        .wd_freeze (wd_freeze)
    );

    mcd_status u_sts (
        .clk   (bkp_clk),
        .por_n (por_n),
        .set   (loss_set),
        .clr   (sts_clr),
        .sts   (miss_sts)
    );

    // R5: status flag is already high when the request starts
    a_r5_sts_with_req: assert property (@(posedge bkp_clk) disable iff (!por_n)
        $rose(rst_req) |-> miss_sts);

    // R4: the request starts together with the clock switch
    a_r4_req_with_sel: assert property (@(posedge bkp_clk) disable iff (!por_n)
        $rose(clk_sel_limp) |-> $rose(rst_req));

    // R9: fallback is held until power-on reset
    a_r9_limp_holds: assert property (@(posedge bkp_clk) disable iff (!por_n)
        clk_sel_limp |=> clk_sel_limp);

    // R6: watchdog freeze tracks the limp selection
    a_r6_freeze_on_limp: assert property (@(posedge bkp_clk) disable iff (!por_n)
        $rose(clk_sel_limp) |-> wd_freeze);

endmodule

// File: tb/tb_mcd_limp_monitor.sv
`timescale 1ns/1ps
module tb_mcd_limp_monitor;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       dev_rst_n = 1'b1;
    logic       osc_clk = 1'b0;
    logic [1:0] clk_mode = 2'b10;
    logic       sts_clr = 1'b0;
    logic       clk_sel_limp, rst_req, miss_sts, wd_freeze;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // oscillator generator controls
    bit osc_run = 1'b0;
    bit osc_rand = 1'b0;
    int osc_hp = 2;
    int osc_left = 2;

    always #2.5 clk = ~clk;

    mcd_limp_monitor dut (
        .bkp_clk      (clk),
        .por_n        (por_n),
        .dev_rst_n    (dev_rst_n),
        .osc_clk      (osc_clk),
        .clk_mode     (clk_mode),
        .sts_clr      (sts_clr),
        .clk_sel_limp (clk_sel_limp),
        .rst_req      (rst_req),
        .miss_sts     (miss_sts),
        .wd_freeze    (wd_freeze)
    );

    // reference model built from the requirements
    bit m_s1, m_s2, m_s3;
    int m_edges, m_gap, m_pls, m_st;
    bit m_sts;

    function automatic bit det_mode(input logic [1:0] m);
        return (m == 2'b01) || (m == 2'b10);
    endfunction

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_edges = 0; m_gap = 0; m_pls = 0; m_st = 0; m_sts = 0;
        end else begin
            bit r, ok, set;
            r   = m_s2 && !m_s3;
            ok  = dev_rst_n && det_mode(clk_mode);
            set = 0;
            case (m_st)
                0: begin
                    if (!ok) m_edges = 0;
                    else if (r) begin
                        if (m_edges == 3) begin m_st = 1; m_edges = 0; m_gap = 0; end
                        else m_edges++;
                    end
                end
                1: begin
                    if (!ok) begin m_st = 0; m_gap = 0; end
                    else if (r) m_gap = 0;
                    else if (m_gap == 15) begin m_st = 2; m_pls = 0; set = 1; end
                    else m_gap++;
                end
                2: begin
                    if (m_pls == 7) m_st = 3;
                    else m_pls++;
                end
                default: m_st = 3;
            endcase
            if (set) m_sts = 1;
            else if (sts_clr) m_sts = 0;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = osc_clk;
        end
    end

    function automatic bit exp_sel();  return m_st >= 2; endfunction
    function automatic bit exp_req();  return m_st == 2; endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3 clk_sel_limp", clk_sel_limp, exp_sel());
        chk("R4 rst_req", rst_req, exp_req());
        chk("R5 miss_sts", miss_sts, m_sts);
        chk("R6 wd_freeze", wd_freeze, exp_sel());
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            if (osc_run) begin
                osc_left--;
                if (osc_left <= 0) begin
                    osc_clk = ~osc_clk;
                    if (osc_rand) osc_hp = 1 + int'($urandom % 6);
                    osc_left = osc_hp;
                end
            end
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            osc_clk = 1'b1; step(2);
            osc_clk = 1'b0; step(2);
        end
    endtask

    task automatic do_por();
        osc_run = 0; osc_clk = 0; sts_clr = 0; dev_rst_n = 1;
        @(negedge clk); por_n = 0;
        @(negedge clk); @(negedge clk);
        por_n = 1;
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h1bad_5eed);

        // R1: power-on state
        do_por();
        chk("R1 clk_sel_limp", clk_sel_limp, 1'b0);
        chk("R1 rst_req", rst_req, 1'b0);
        chk("R1 miss_sts", miss_sts, 1'b0);
        chk("R1 wd_freeze", wd_freeze, 1'b0);

        // R2: oscillator absent from power-up never trips
        clk_mode = 2'b10;
        step(40);
        chk("R2 no edges no trip", clk_sel_limp, 1'b0);
        // R2: three edges then a long pause: still unarmed
        pulses(3);
        step(40);
        chk("R2 three edges no trip", clk_sel_limp, 1'b0);
        // fourth edge arms; pause now trips (R3, R4, R5)
        pulses(1);
        step(30);
        chk("R3 trip after arming", clk_sel_limp, 1'b1);
        chk("R5 status set", miss_sts, 1'b1);
        chk("R4 pulse finished", rst_req, 1'b0);

        // R9: oscillator back, limp kept
        osc_rand = 0; osc_hp = 2; osc_left = 2; osc_run = 1;
        step(50);
        chk("R9 limp held", clk_sel_limp, 1'b1);
        // R8: device reset after loss has no effect
        dev_rst_n = 0; step(3); dev_rst_n = 1; step(2);
        chk("R8 limp kept through dev reset", clk_sel_limp, 1'b1);
        chk("R8 status kept through dev reset", miss_sts, 1'b1);
        // R5: clear strobe
        sts_clr = 1; step(1); sts_clr = 0; step(1);
        chk("R5 status cleared", miss_sts, 1'b0);

        // R7: off and reserved modes never trip
        do_por();
        clk_mode = 2'b00;
        pulses(8); step(40);
        chk("R7 off mode no trip", clk_sel_limp, 1'b0);
        clk_mode = 2'b11;
        pulses(8); step(40);
        chk("R7 reserved mode no trip", clk_sel_limp, 1'b0);
        // R7: leaving a mode without detection discards edges
        clk_mode = 2'b01;
        pulses(3); clk_mode = 2'b00; step(1); clk_mode = 2'b01;
        pulses(1); step(40);
        chk("R7 edges discarded by mode", clk_sel_limp, 1'b0);
        pulses(4); step(30);
        chk("R7 bypass mode trips", clk_sel_limp, 1'b1);

        // R8: device reset before arming discards edges
        do_por();
        clk_mode = 2'b10;
        pulses(3); dev_rst_n = 0; step(1); dev_rst_n = 1;
        pulses(1); step(40);
        chk("R8 dev reset disarms", clk_sel_limp, 1'b0);

        // random rounds, checked every cycle against the model
        for (int round = 0; round < 12; round++) begin
            do_por();
            clk_mode = (($urandom % 4) == 0) ? 2'b01 : 2'b10;
            osc_rand = 1; osc_hp = 3; osc_left = 3; osc_run = 1;
            for (int c = 0; c < 400; c++) begin
                int unsigned r;
                r = $urandom % 100;
                if (osc_run && r == 0) osc_run = 0;
                else if (!osc_run && r < 7) osc_run = 1;
                sts_clr = (r >= 10 && r < 13);
                dev_rst_n = !(r == 20);
                if (($urandom % 150) == 0) clk_mode = 2'($urandom % 4);
                step(1);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule